// File: doc/BRIEF.md
# Subchannel Engine Binding Dispatcher

This block sits between a command-stream front end and a set of execution engines. Every incoming method call carries a method number, a 32-bit argument, a 3-bit subchannel selector and a remaining-word count. The dispatcher keeps a small table that binds each of its eight subchannels to an engine identifier. A call to method 0 rewrites the table entry for its subchannel. Every other call is steered to the output port whose engine identifier matches the one bound to that subchannel.

Method numbers below 0x40 belong to the dispatcher itself and never reach an engine. One engine port is marked as the macro-capable engine. For that engine, calls to methods at or above 0xE00 are not forwarded. They are gathered into a parameter group: a group opens on an even method, continues only on that method plus one, and closes when a call arrives with a count of 1 or less. The closed group is presented on a dedicated output for one cycle. Executing the macro and the engines themselves lie outside the block.

All outputs are registered. A call accepted in cycle N shows its effect on the outputs in cycle N+1. A binding written in cycle N is used by a call in cycle N+1.

Top module: `method_dispatch`

## Requirements
- R1: After reset, `eng_valid` is 0, `macro_valid` is 0 and all three error flags are 0. Every binding entry holds identifier 0, which matches no port, so a call on any subchannel before a bind is treated as unbound.
- R2: A call with method 0 stores `call_arg[ID_W-1:0]` as the binding of `call_subch`. It raises no `eng_valid` bit, no `macro_valid` and no error flag.
- R3: A call with method of 0x40 or more, on a subchannel bound to an identifier that a port carries, asserts exactly that port's bit of `eng_valid` one cycle later. The cycle also carries the call's method, argument, subchannel and count unchanged. In the default build, port k carries identifier k+1.
- R4: A call with method of 0x40 or more, on a subchannel whose bound identifier matches no port, is dropped. It sets the sticky flag `err_unbound`, which stays set until reset.
- R5: A call with method from 0x01 to 0x3F is dropped with no output and no flag change.
- R6: On the subchannel bound to the macro port (default port 1, identifier 2), methods 0xE00 and up are not forwarded. Their arguments are stored in arrival order, word 0 at `macro_params[31:0]`.
- R7: An accepted macro word with count 0 or 1 closes the group. For one cycle, `macro_valid` is 1, `macro_method` is the even opening method, and `macro_len` is the number of stored words.
- R8: A macro word that opens a group on an odd method, or that continues a group on any method other than the opening method plus one, is discarded. It sets the sticky flag `err_macro_seq`.
- R9: The group holds at most 16 words. Further words are discarded and set the sticky flag `err_macro_ovf`. A closing word still closes the group, with `macro_len` equal to 16.
- R10: Methods 0xE00 and up on subchannels bound to any other engine are forwarded like ordinary calls.
- R11: Each subchannel's binding is independent. A rebind takes effect for the very next call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_valid | input | 1 | A method call is present this cycle |
| call_method | input | METH_W (13) | Method number |
| call_arg | input | DATA_W (32) | Method argument |
| call_subch | input | SUB_W (3) | Subchannel selector |
| call_count | input | CNT_W (13) | Remaining words in the current command, this one included |
| eng_valid | output | NUM_ENG (5) | One-hot forward strobe, one bit per engine port |
| eng_method | output | METH_W (13) | Forwarded method |
| eng_arg | output | DATA_W (32) | Forwarded argument |
| eng_subch | output | SUB_W (3) | Forwarded subchannel |
| eng_count | output | CNT_W (13) | Forwarded count |
| macro_valid | output | 1 | A macro parameter group has just closed |
| macro_method | output | METH_W (13) | Opening method of the closed group |
| macro_len | output | LEN_W (5) | Number of stored words, 1 to 16 |
| macro_params | output | MAC_DEPTH*DATA_W (512) | Stored words, word i at bits [32i+31:32i] |
| err_unbound | output | 1 | Sticky: a call hit an unbound subchannel |
| err_macro_seq | output | 1 | Sticky: a macro word broke the even-open / plus-one rule |
| err_macro_ovf | output | 1 | Sticky: a macro group exceeded 16 words |

## Verification
The bench targets a call issued in the cycle right after a rebind of the same subchannel. A design that read a stale table entry would send that call to the old port. Macro groups of exactly one word are tested, with count 0 as well as count 1. An off-by-one close check would either never emit such a group or emit it with a length of zero. Groups of 17 and more words are also tested: a design that wrapped the write index would overwrite word 0 instead of flagging overflow and reporting a length of 16. Odd openings and wrong continuation methods are mixed into random traffic, along with the boundary methods 0x3F, 0x40, 0xDFF and 0xE00. A design that mishandled those boundaries would forward a reserved method, swallow an ordinary one, or divert macro-range calls of other engines.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;

    // Classification of one incoming call.
    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,
        ACT_BIND    = 3'd1,
        ACT_RSVD    = 3'd2,
        ACT_UNBOUND = 3'd3,
        ACT_FWD     = 3'd4,
        ACT_MACRO   = 3'd5
    } act_e;

    localparam int DEF_METH_W    = 13;
    localparam int DEF_DATA_W    = 32;
    localparam int DEF_CNT_W     = 13;
    localparam int DEF_ID_W      = 16;
    localparam int DEF_NUM_SUB   = 8;
    localparam int DEF_NUM_ENG   = 5;
    localparam int DEF_MAC_DEPTH = 16;

endpackage

// File: rtl/mdisp_bind_table.sv
module mdisp_bind_table #(
    parameter int          NUM_SUB    = 8,
    parameter int          ID_W       = 16,
    parameter logic [15:0] INVALID_ID = 16'h0000,
    localparam int         SUB_W      = $clog2(NUM_SUB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SUB_W-1:0] wr_sub,
    input  logic [ID_W-1:0]  wr_id,
    input  logic [SUB_W-1:0] rd_sub,
    output logic [ID_W-1:0]  rd_id
);

    typedef struct packed {
        logic [NUM_SUB-1:0][ID_W-1:0] ids;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.ids[wr_sub] = wr_id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SUB; i++) begin
                tbl_q.ids[i] <= ID_W'(INVALID_ID);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Reads see the registered table; a write lands for the next call.
    assign rd_id = tbl_q.ids[rd_sub];

    // R2 / R11: a write is visible in the entry one cycle later
    p_bind_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl_q.ids[$past(wr_sub)] == $past(wr_id));

    // R11: entries other than the written one keep their value
    p_bind_other_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_sub != wr_sub) |=> tbl_q.ids[$past(rd_sub)] == $past(rd_id));

endmodule

// File: rtl/mdisp_decode.sv
module mdisp_decode
    import mdisp_pkg::*;
#(
    parameter int                      METH_W     = 13,
    parameter int                      ID_W       = 16,
    parameter int                      NUM_ENG    = 5,
    parameter logic [NUM_ENG*ID_W-1:0] ENG_IDS    = {16'd5, 16'd4, 16'd3, 16'd2, 16'd1},
    parameter int                      RSV_LIMIT  = 'h40,
    parameter int                      MACRO_BASE = 'hE00,
    parameter int                      MACRO_PORT = 1
) (
    input  logic               call_valid,
    input  logic [METH_W-1:0]  call_method,
    input  logic [ID_W-1:0]    bound_id,
    output act_e               act,
    output logic [NUM_ENG-1:0] port_hit
);

    logic [NUM_ENG-1:0] id_match;

    for (genvar k = 0; k < NUM_ENG; k++) begin : g_match
        assign id_match[k] = (bound_id == ENG_IDS[k*ID_W +: ID_W]);
    end

    // Lowest matching port wins, so the strobe is one-hot even with
    // a duplicated identifier in the parameter list.
    assign port_hit = id_match & (~id_match + NUM_ENG'(1));

    always_comb begin
        if (!call_valid) begin
            act = ACT_IDLE;
        end else if (call_method == '0) begin
            act = ACT_BIND;
        end else if (call_method < METH_W'(RSV_LIMIT)) begin
            act = ACT_RSVD;
        end else if (id_match == '0) begin
            act = ACT_UNBOUND;
        end else if (port_hit[MACRO_PORT] && call_method >= METH_W'(MACRO_BASE)) begin
            act = ACT_MACRO;
        end else begin
            act = ACT_FWD;
        end
    end

endmodule

// File: rtl/mdisp_macro_collect.sv
module mdisp_macro_collect #(
    parameter int  DEPTH  = 16,
    parameter int  DATA_W = 32,
    parameter int  METH_W = 13,
    parameter int  CNT_W  = 13,
    localparam int LEN_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [METH_W-1:0]       in_method,
    input  logic [DATA_W-1:0]       in_arg,
    input  logic [CNT_W-1:0]        in_count,
    output logic                    mac_valid,
    output logic [METH_W-1:0]       mac_method,
    output logic [LEN_W-1:0]        mac_len,
    output logic [DEPTH*DATA_W-1:0] mac_params,
    output logic                    err_seq,
    output logic                    err_ovf
);

    typedef struct packed {
        logic                          active;
        logic                          done;
        logic [METH_W-1:0]             method;
        logic [LEN_W-1:0]              len;
        logic [DEPTH-1:0][DATA_W-1:0]  words;
        logic                          err_seq;
        logic                          err_ovf;
    } col_t;

    col_t col_d, col_q;
    logic closing;

    assign closing = (in_count <= CNT_W'(1));

    always_comb begin
        col_d      = col_q;
        col_d.done = 1'b0;
        if (in_valid) begin
            if (!col_q.active) begin
                if (in_method[0]) begin
                    col_d.err_seq = 1'b1;
                end else begin
                    col_d.method   = in_method;
                    col_d.words[0] = in_arg;
                    col_d.len      = LEN_W'(1);
                    col_d.done     = closing;
                    col_d.active   = !closing;
                end
            end else if (in_method != (col_q.method | METH_W'(1))) begin
                col_d.err_seq = 1'b1;
            end else begin
                if (col_q.len < LEN_W'(DEPTH)) begin
                    col_d.words[col_q.len[IDX_W-1:0]] = in_arg;
                    col_d.len = col_q.len + LEN_W'(1);
                end else begin
                    col_d.err_ovf = 1'b1;
                end
                col_d.done   = closing;
                col_d.active = !closing;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign mac_valid  = col_q.done;
    assign mac_method = col_q.method;
    assign mac_len    = col_q.len;
    assign mac_params = col_q.words;
    assign err_seq    = col_q.err_seq;
    assign err_ovf    = col_q.err_ovf;

    // R7 / R9: a closed group reports between 1 and DEPTH words
    p_len_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid |-> (mac_len >= LEN_W'(1) && mac_len <= LEN_W'(DEPTH)));

    // R8: a closed group always opened on an even method
    p_even_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid |-> !mac_method[0]);

    // R8: sequence flag is sticky
    p_seq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_seq |=> err_seq);

    // R9: overflow flag is sticky and only rises with a full buffer
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> err_ovf);
    p_ovf_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovf) |-> mac_len == LEN_W'(DEPTH));

endmodule

// File: rtl/method_dispatch.sv
module method_dispatch
    import mdisp_pkg::*;
#(
    parameter int                      METH_W     = DEF_METH_W,
    parameter int                      DATA_W     = DEF_DATA_W,
    parameter int                      CNT_W      = DEF_CNT_W,
    parameter int                      ID_W       = DEF_ID_W,
    parameter int                      NUM_SUB    = DEF_NUM_SUB,
    parameter int                      NUM_ENG    = DEF_NUM_ENG,
    parameter int                      MAC_DEPTH  = DEF_MAC_DEPTH,
    parameter logic [NUM_ENG*ID_W-1:0] ENG_IDS    = {16'd5, 16'd4, 16'd3, 16'd2, 16'd1},
    parameter int                      MACRO_PORT = 1,
    parameter int                      RSV_LIMIT  = 'h40,
    parameter int                      MACRO_BASE = 'hE00,
    localparam int                     SUB_W      = $clog2(NUM_SUB),
    localparam int                     LEN_W      = $clog2(MAC_DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        call_valid,
    input  logic [METH_W-1:0]           call_method,
    input  logic [DATA_W-1:0]           call_arg,
    input  logic [SUB_W-1:0]            call_subch,
    input  logic [CNT_W-1:0]            call_count,
    output logic [NUM_ENG-1:0]          eng_valid,
    output logic [METH_W-1:0]           eng_method,
    output logic [DATA_W-1:0]           eng_arg,
    output logic [SUB_W-1:0]            eng_subch,
    output logic [CNT_W-1:0]            eng_count,
    output logic                        macro_valid,
    output logic [METH_W-1:0]           macro_method,
    output logic [LEN_W-1:0]            macro_len,
    output logic [MAC_DEPTH*DATA_W-1:0] macro_params,
    output logic                        err_unbound,
    output logic                        err_macro_seq,
    output logic                        err_macro_ovf
);

    typedef struct packed {
        logic [NUM_ENG-1:0] ev;
        logic [METH_W-1:0]  meth;
        logic [DATA_W-1:0]  arg;
        logic [SUB_W-1:0]   sub;
        logic [CNT_W-1:0]   cnt;
        logic               unbound;
    } fwd_t;

    fwd_t               fwd_d, fwd_q;
    logic [ID_W-1:0]    bound_id;
    act_e               act;
    logic [NUM_ENG-1:0] port_hit;

    mdisp_bind_table #(
        .NUM_SUB    (NUM_SUB),
        .ID_W       (ID_W),
        .INVALID_ID (16'h0000)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (act == ACT_BIND),
        .wr_sub (call_subch),
        .wr_id  (call_arg[ID_W-1:0]),
        .rd_sub (call_subch),
        .rd_id  (bound_id)
    );

    mdisp_decode #(
        .METH_W     (METH_W),
        .ID_W       (ID_W),
        .NUM_ENG    (NUM_ENG),
        .ENG_IDS    (ENG_IDS),
        .RSV_LIMIT  (RSV_LIMIT),
        .MACRO_BASE (MACRO_BASE),
        .MACRO_PORT (MACRO_PORT)
    ) u_decode (
        .call_valid  (call_valid),
        .call_method (call_method),
        .bound_id    (bound_id),
        .act         (act),
        .port_hit    (port_hit)
    );

    mdisp_macro_collect #(
        .DEPTH  (MAC_DEPTH),
        .DATA_W (DATA_W),
        .METH_W (METH_W),
        .CNT_W  (CNT_W)
    ) u_macro (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (act == ACT_MACRO),
        .in_method  (call_method),
        .in_arg     (call_arg),
        .in_count   (call_count),
        .mac_valid  (macro_valid),
        .mac_method (macro_method),
        .mac_len    (macro_len),
        .mac_params (macro_params),
        .err_seq    (err_macro_seq),
        .err_ovf    (err_macro_ovf)
    );

    always_comb begin
        fwd_d    = fwd_q;
        fwd_d.ev = '0;
        if (act == ACT_FWD) begin
            fwd_d.ev   = port_hit;
            fwd_d.meth = call_method;
            fwd_d.arg  = call_arg;
            fwd_d.sub  = call_subch;
            fwd_d.cnt  = call_count;
        end
        if (act == ACT_UNBOUND) begin
            fwd_d.unbound = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q <= '0;
        end else begin
            fwd_q <= fwd_d;
        end
    end

    assign eng_valid   = fwd_q.ev;
    assign eng_method  = fwd_q.meth;
    assign eng_arg     = fwd_q.arg;
    assign eng_subch   = fwd_q.sub;
    assign eng_count   = fwd_q.cnt;
    assign err_unbound = fwd_q.unbound;

    // R3: at most one engine strobe at a time
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_valid));

    // R3: a forwarded call appears next cycle on the decoded port, unaltered
    p_fwd_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_FWD) |=> (eng_valid == $past(port_hit)
                              && eng_arg == $past(call_arg)
                              && eng_method == $past(call_method)));

    // R2: a bind produces no engine strobe and no macro output
    p_bind_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && call_method == '0) |=> (eng_valid == '0 && !macro_valid));

    // R5: reserved methods vanish
    p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && call_method != '0 && call_method < METH_W'(RSV_LIMIT))
        |=> (eng_valid == '0 && !macro_valid));

    // R4: unbound calls raise the flag, which then stays set
    p_unbound_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_UNBOUND) |=> err_unbound);
    p_unbound_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_unbound |=> err_unbound);

    // R6: captured macro words never reach the macro engine port
    p_macro_absorb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_MACRO) |=> !eng_valid[MACRO_PORT]);

endmodule

// File: tb/method_dispatch_test.sv
module method_dispatch_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         call_valid = 1'b0;
    logic [12:0]  call_method = '0;
    logic [31:0]  call_arg = '0;
    logic [2:0]   call_subch = '0;
    logic [12:0]  call_count = '0;
    logic [4:0]   eng_valid;
    logic [12:0]  eng_method;
    logic [31:0]  eng_arg;
    logic [2:0]   eng_subch;
    logic [12:0]  eng_count;
    logic         macro_valid;
    logic [12:0]  macro_method;
    logic [4:0]   macro_len;
    logic [511:0] macro_params;
    logic         err_unbound, err_macro_seq, err_macro_ovf;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    method_dispatch uut (
        .clk(clk), .rst_n(rst_n),
        .call_valid(call_valid), .call_method(call_method), .call_arg(call_arg),
        .call_subch(call_subch), .call_count(call_count),
        .eng_valid(eng_valid), .eng_method(eng_method), .eng_arg(eng_arg),
        .eng_subch(eng_subch), .eng_count(eng_count),
        .macro_valid(macro_valid), .macro_method(macro_method), .macro_len(macro_len),
        .macro_params(macro_params),
        .err_unbound(err_unbound), .err_macro_seq(err_macro_seq), .err_macro_ovf(err_macro_ovf)
    );

    // ---------------- reference model state ----------------
    logic [15:0] m_bind [8];
    logic        m_act;
    logic [12:0] m_meth;
    int          m_len;
    logic [31:0] m_buf [16];
    logic        e_unb, e_seq, e_ovf;
    logic [4:0]  x_ev;
    logic [12:0] x_meth, x_cnt;
    logic [31:0] x_arg;
    logic [2:0]  x_sub;
    logic        x_mv;
    logic [12:0] x_mmeth;
    int          x_mlen;
    logic [31:0] x_mbuf [16];

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected outputs one cycle after a call, derived from R1..R11.
    task automatic model(input logic v, input logic [12:0] m, input logic [31:0] a,
                         input logic [2:0] s, input logic [12:0] c);
        int port;
        x_ev = '0;
        x_mv = 1'b0;
        if (v) begin
            if (m == 13'h0) begin
                m_bind[s] = a[15:0];                          // R2
            end else if (m < 13'h40) begin
                // R5: nothing
            end else begin
                port = -1;
                for (int k = 0; k < 5; k++) if (port < 0 && m_bind[s] == 16'(k + 1)) port = k;
                if (port < 0) begin
                    e_unb = 1'b1;                             // R4
                end else if (port == 1 && m >= 13'hE00) begin // R6
                    if (!m_act) begin
                        if (m[0]) e_seq = 1'b1;               // R8
                        else begin
                            m_meth = m; m_buf[0] = a; m_len = 1;
                            if (c <= 1) x_mv = 1'b1; else m_act = 1'b1;
                        end
                    end else if (m != (m_meth | 13'h1)) begin
                        e_seq = 1'b1;                         // R8
                    end else begin
                        if (m_len < 16) begin m_buf[m_len] = a; m_len++; end
                        else e_ovf = 1'b1;                    // R9
                        if (c <= 1) begin x_mv = 1'b1; m_act = 1'b0; end
                    end
                    if (x_mv) begin
                        x_mmeth = m_meth; x_mlen = m_len;
                        for (int i = 0; i < 16; i++) x_mbuf[i] = m_buf[i];
                    end
                end else begin
                    x_ev = 5'(1 << port);                     // R3 / R10
                    x_meth = m; x_arg = a; x_sub = s; x_cnt = c;
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "eng_valid", 64'(eng_valid), 64'(x_ev));
        if (x_ev != '0) begin
            chk(tag, "eng_method", 64'(eng_method), 64'(x_meth));
            chk(tag, "eng_arg",    64'(eng_arg),    64'(x_arg));
            chk(tag, "eng_subch",  64'(eng_subch),  64'(x_sub));
            chk(tag, "eng_count",  64'(eng_count),  64'(x_cnt));
        end
        chk(tag, "macro_valid", 64'(macro_valid), 64'(x_mv));
        if (x_mv) begin
            chk("R7", "macro_method", 64'(macro_method), 64'(x_mmeth));
            chk("R7", "macro_len",    64'(macro_len),    64'(x_mlen));
            for (int i = 0; i < x_mlen; i++)
                chk("R6", "macro_param", 64'(macro_params[i*32 +: 32]), 64'(x_mbuf[i]));
        end
        chk("R4", "err_unbound",   64'(err_unbound),   64'(e_unb));
        chk("R8", "err_macro_seq", 64'(err_macro_seq), 64'(e_seq));
        chk("R9", "err_macro_ovf", 64'(err_macro_ovf), 64'(e_ovf));
    endtask

    // Called at a falling edge: drive, let one rising edge pass, check.
    task automatic call(input logic [12:0] m, input logic [31:0] a, input logic [2:0] s,
                        input logic [12:0] c, input string tag);
        call_valid = 1'b1; call_method = m; call_arg = a; call_subch = s; call_count = c;
        model(1'b1, m, a, s, c);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        call_valid = 1'b0;
        model(1'b0, '0, '0, '0, '0);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic group(input logic [2:0] s, input logic [12:0] m, input int n, input string tag);
        for (int i = 0; i < n; i++)
            call((i == 0) ? m : (m | 13'h1), $urandom, s, 13'(n - i), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        for (int i = 0; i < 8; i++) m_bind[i] = 16'h0;
        m_act = 0; m_len = 0; m_meth = 0; e_unb = 0; e_seq = 0; e_ovf = 0;
        for (int i = 0; i < 16; i++) begin m_buf[i] = 0; x_mbuf[i] = 0; end
        x_ev = 0; x_mv = 0; x_mmeth = 0; x_mlen = 0;
        seed = $urandom(32'h00C0FFEE);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compare("R1");
        // R1: a call before any bind is unbound
        call(13'h100, 32'h1, 3'd0, 13'd1, "R1");
        idle("R4");

        // R2: binds, silent
        for (int s = 0; s < 5; s++) call(13'h0, 32'(s + 1), 3'(s), 13'd1, "R2");
        call(13'h0, 32'd2, 3'd6, 13'd1, "R2");
        // R3: forward to each bound port
        for (int s = 0; s < 5; s++) call(13'h40, 32'hA000 + 32'(s), 3'(s), 13'd7, "R3");
        call(13'hDFF, 32'hBEEF, 3'd1, 13'd2, "R3");
        // R5: reserved boundary
        call(13'h3F, 32'h55, 3'd0, 13'd1, "R5");
        call(13'h01, 32'h66, 3'd2, 13'd1, "R5");
        // R11: rebind then immediate use
        call(13'h0, 32'd4, 3'd0, 13'd1, "R11");
        call(13'h200, 32'h77, 3'd0, 13'd1, "R11");
        call(13'h200, 32'h78, 3'd2, 13'd1, "R11");
        // R4: unmatched id
        call(13'h0, 32'd9, 3'd7, 13'd1, "R4");
        call(13'h300, 32'h1, 3'd7, 13'd1, "R4");
        // R10: macro range on a non-macro engine forwards
        call(13'hE00, 32'h99, 3'd3, 13'd3, "R10");
        // R6 / R7: groups on the macro engine (subchannel 1 -> id 2)
        group(3'd1, 13'hE00, 3, "R6");
        call(13'hE10, 32'h1234, 3'd1, 13'd0, "R7");     // single word, count 0
        call(13'hE12, 32'h4321, 3'd6, 13'd1, "R7");     // single word, count 1
        idle("R7");
        // R9: overflow
        group(3'd6, 13'hE20, 20, "R9");
        // R8: odd open, then wrong continuation
        call(13'hE31, 32'h5, 3'd1, 13'd1, "R8");
        call(13'hE40, 32'h6, 3'd1, 13'd3, "R8");
        call(13'hE45, 32'h7, 3'd1, 13'd2, "R8");
        call(13'hE41, 32'h8, 3'd1, 13'd1, "R8");
        idle("R8");

        // Random mix
        for (int it = 0; it < 700; it++) begin
            int r;
            logic [2:0] s;
            r = int'($urandom % 10);
            s = 3'($urandom);
            case (r)
                0, 1: call(13'h0, 32'($urandom % 7), s, 13'($urandom), "R11");
                2:    call(13'(1 + $urandom % 13'h3F), $urandom, s, 13'($urandom), "R5");
                3, 4, 5, 6:
                      call(13'(13'h40 + $urandom % 13'hDC0), $urandom, s, 13'($urandom % 9), "R3");
                7, 8: group(s, 13'(13'hE00 + 2 * ($urandom % 256)), int'(1 + $urandom % 20), "R6");
                default:
                      call(13'(13'hE00 + $urandom % 512), $urandom, s, 13'($urandom % 3), "R8");
            endcase
            if ($urandom % 4 == 0) idle("R1");
        end
        idle("R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule